// File: doc/BRIEF.md
# Processor Bus Cycle Decoder

This block sits beside an 8-bit processor that has a 16-bit address bus and active-low bus strobes. It watches the memory-request, port-request, read, write, refresh and opcode-fetch strobes together with the address. From these it produces separate active-low selects for a read-only code region, a read/write data region and a small bank of I/O ports. It also produces an active-low output enable for the data-bus buffer, which is active only while a read select is active.

The two memory regions are set by parameters. By default the code region is 0x0000–0x3FFF, the data region is 0x4000–0xBFFF, and 0xC000–0xFFFF is unmapped. Ports are decoded from the low address byte only. Each port owns a group of `1 << PORT_SHIFT` consecutive addresses, starting at `PORT_BASE`.

Refresh cycles and interrupt-acknowledge cycles drive the same strobes as ordinary accesses. The decoder filters them out, so that no memory or port device ever sees a strobe during those cycles. The block is purely combinational: each select follows the input strobes within the same cycle.

Top module: `bus_cycle_decoder`

## Requirements
- R1: With mreq_n=0, rd_n=0, wr_n=1, iorq_n=1 and rfsh_n=1, an address below 0x4000 drives rom_rd_n=0, and an address in 0x4000–0xBFFF drives ram_rd_n=0. The level of m1_n does not change this.
- R2: With mreq_n=0, wr_n=0, rd_n=1, iorq_n=1 and rfsh_n=1, an address in 0x4000–0xBFFF drives ram_wr_n=0. A write below 0x4000 asserts no select.
- R3: A memory cycle with an address in 0xC000–0xFFFF asserts no select.
- R4: With iorq_n=0, m1_n=1, mreq_n=1 and exactly one of rd_n/wr_n low, a low address byte L in 0x10–0x1F selects port k=(L-0x10)>>2. The select is io_rd_n[k]=0 for a read and io_wr_n[k]=0 for a write. Other low bytes select no port. addr[15:8] and rfsh_n have no effect.
- R5: mreq_n=0 together with rfsh_n=0 asserts no select, whatever rd_n, wr_n and the address are.
- R6: iorq_n=0 together with m1_n=0 asserts no port select.
- R7: rd_n=0 together with wr_n=0, or mreq_n=0 together with iorq_n=0, asserts no select.
- R8: With mreq_n=iorq_n=1, or with rd_n=wr_n=1, every select and dbus_oe_n are high. This includes the state with all strobes high.
- R9: At most one of rom_rd_n, ram_rd_n, ram_wr_n, io_rd_n[*] and io_wr_n[*] is low at any time.
- R10: dbus_oe_n is low exactly when rom_rd_n, ram_rd_n or one of io_rd_n[*] is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mreq_n | input | 1 | Memory request strobe, active low |
| iorq_n | input | 1 | Port request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rfsh_n | input | 1 | Refresh indicator, active low |
| m1_n | input | 1 | Opcode-fetch / first machine cycle, active low |
| addr | input | 16 | Processor address bus |
| rom_rd_n | output | 1 | Code region read select |
| ram_rd_n | output | 1 | Data region read select |
| ram_wr_n | output | 1 | Data region write select |
| io_rd_n | output | 4 | Per-port read selects |
| io_wr_n | output | 4 | Per-port write selects |
| dbus_oe_n | output | 1 | Data-bus buffer enable toward the processor |

## Verification
The embedded checks assume that the strobe inputs are settled, two-state levels whenever they are evaluated. They also assume that the two region windows do not overlap. They make no assumption about which strobe combinations the processor would legally produce, so illegal pairings such as read with write, or memory request with port request, lie inside their scope. The stimulus changes all inputs together, one clock after the last sample, and holds them stable until the next sample. It visits all 64 strobe combinations at each region and port boundary and across a strided sweep of the 64K space, which includes high bytes that must be ignored for ports.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE     = 3'd0,
    CYC_MEM_RD   = 3'd1,
    CYC_MEM_WR   = 3'd2,
    CYC_IO_RD    = 3'd3,
    CYC_IO_WR    = 3'd4,
    CYC_REFRESH  = 3'd5,
    CYC_INTACK   = 3'd6,
    CYC_CONFLICT = 3'd7
  } cyc_e;

  // Half-open window test: base <= a < base + size
  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] base,
                                     input logic [31:0] size);
    return (a >= base) && (a < base + size);
  endfunction

  // Slot number of an address inside a window of equal power-of-two groups
  function automatic logic [31:0] slot_of(input logic [31:0] a,
                                          input logic [31:0] base,
                                          input int unsigned shift);
    return (a - base) >> shift;
  endfunction

endpackage

// File: rtl/bcd_cycle_classify.sv
module bcd_cycle_classify
  import bcd_pkg::*;
(
  input  logic mreq_n,
  input  logic iorq_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic rfsh_n,
  input  logic m1_n,
  output cyc_e cyc
);

  logic mreq, iorq, rd, wr, rfsh, m1;
  logic clash, refresh_ev, intack_ev;

  assign mreq = ~mreq_n;
  assign iorq = ~iorq_n;
  assign rd   = ~rd_n;
  assign wr   = ~wr_n;
  assign rfsh = ~rfsh_n;
  assign m1   = ~m1_n;

  // Named events for the checks and for readability
  assign clash      = (rd & wr) | (mreq & iorq);
  assign refresh_ev = mreq & rfsh;
  assign intack_ev  = iorq & m1;

  always_comb begin
    cyc = CYC_IDLE;
    if (clash)                 cyc = CYC_CONFLICT;
    else if (refresh_ev)       cyc = CYC_REFRESH;
    else if (intack_ev)        cyc = CYC_INTACK;
    else if (mreq && rd)       cyc = CYC_MEM_RD;
    else if (mreq && wr)       cyc = CYC_MEM_WR;
    else if (iorq && rd)       cyc = CYC_IO_RD;
    else if (iorq && wr)       cyc = CYC_IO_WR;
  end

  always_comb begin
    p_fetch_is_read_r1: assert (!(mreq && rd && !wr && !iorq && !rfsh) || cyc == CYC_MEM_RD)
      else $error("memory read not classified");
    p_refresh_kind_r5: assert (!(refresh_ev && !clash) || cyc == CYC_REFRESH)
      else $error("refresh not classified");
  end

endmodule

// File: rtl/bcd_region_map.sv
module bcd_region_map
  import bcd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned ROM_BASE = 32'h0000,
  parameter int unsigned ROM_SIZE = 32'h4000,
  parameter int unsigned RAM_BASE = 32'h4000,
  parameter int unsigned RAM_SIZE = 32'h8000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              rom_hit,
  output logic              ram_hit
);

  localparam int unsigned PAD_W = 32 - ADDR_W;

  logic [31:0] a_ext;
  assign a_ext   = {{PAD_W{1'b0}}, addr};
  assign rom_hit = in_window(a_ext, ROM_BASE, ROM_SIZE);
  assign ram_hit = in_window(a_ext, RAM_BASE, RAM_SIZE);

  always_comb begin
    p_region_excl_r3: assert (!(rom_hit && ram_hit))
      else $error("code and data windows overlap");
  end

endmodule

// File: rtl/bcd_port_decode.sv
module bcd_port_decode
  import bcd_pkg::*;
#(
  parameter int unsigned PORT_AW    = 8,
  parameter int unsigned PORT_BASE  = 32'h10,
  parameter int unsigned PORT_SHIFT = 2,
  parameter int unsigned NUM_PORTS  = 4
) (
  input  logic [PORT_AW-1:0]   lo_addr,
  output logic [NUM_PORTS-1:0] port_sel
);

  localparam int unsigned SPAN  = NUM_PORTS << PORT_SHIFT;
  localparam int unsigned PAD_W = 32 - PORT_AW;

  logic [31:0] lo_ext;
  logic        win_hit;
  logic [31:0] slot;

  assign lo_ext  = {{PAD_W{1'b0}}, lo_addr};
  assign win_hit = in_window(lo_ext, PORT_BASE, SPAN);
  assign slot    = slot_of(lo_ext, PORT_BASE, PORT_SHIFT);

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    assign port_sel[g] = win_hit && (slot == 32'(g));
  end

  always_comb begin
    p_port_onehot_r4: assert ($onehot0(port_sel))
      else $error("two ports decoded at once");
  end

endmodule

// File: rtl/bus_cycle_decoder.sv
module bus_cycle_decoder
  import bcd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned ROM_BASE   = 32'h0000,
  parameter int unsigned ROM_SIZE   = 32'h4000,
  parameter int unsigned RAM_BASE   = 32'h4000,
  parameter int unsigned RAM_SIZE   = 32'h8000,
  parameter int unsigned PORT_AW    = 8,
  parameter int unsigned PORT_BASE  = 32'h10,
  parameter int unsigned PORT_SHIFT = 2,
  parameter int unsigned NUM_PORTS  = 4
) (
  input  logic                 mreq_n,
  input  logic                 iorq_n,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic                 rfsh_n,
  input  logic                 m1_n,
  input  logic [ADDR_W-1:0]    addr,
  output logic                 rom_rd_n,
  output logic                 ram_rd_n,
  output logic                 ram_wr_n,
  output logic [NUM_PORTS-1:0] io_rd_n,
  output logic [NUM_PORTS-1:0] io_wr_n,
  output logic                 dbus_oe_n
);

  localparam int unsigned SEL_W = 3 + 2 * NUM_PORTS;

  cyc_e                 cyc;
  logic                 rom_hit, ram_hit;
  logic [NUM_PORTS-1:0] port_sel;
  logic                 is_mem_rd, is_mem_wr, is_io_rd, is_io_wr;
  logic [SEL_W-1:0]     sel_active;

  bcd_cycle_classify u_cls (
    .mreq_n (mreq_n),
    .iorq_n (iorq_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .rfsh_n (rfsh_n),
    .m1_n   (m1_n),
    .cyc    (cyc)
  );

  bcd_region_map #(
    .ADDR_W   (ADDR_W),
    .ROM_BASE (ROM_BASE),
    .ROM_SIZE (ROM_SIZE),
    .RAM_BASE (RAM_BASE),
    .RAM_SIZE (RAM_SIZE)
  ) u_map (
    .addr    (addr),
    .rom_hit (rom_hit),
    .ram_hit (ram_hit)
  );

  bcd_port_decode #(
    .PORT_AW    (PORT_AW),
    .PORT_BASE  (PORT_BASE),
    .PORT_SHIFT (PORT_SHIFT),
    .NUM_PORTS  (NUM_PORTS)
  ) u_port (
    .lo_addr  (addr[PORT_AW-1:0]),
    .port_sel (port_sel)
  );

  assign is_mem_rd = (cyc == CYC_MEM_RD);
  assign is_mem_wr = (cyc == CYC_MEM_WR);
  assign is_io_rd  = (cyc == CYC_IO_RD);
  assign is_io_wr  = (cyc == CYC_IO_WR);

  assign rom_rd_n  = ~(is_mem_rd & rom_hit);
  assign ram_rd_n  = ~(is_mem_rd & ram_hit);
  assign ram_wr_n  = ~(is_mem_wr & ram_hit);
  assign io_rd_n   = ~({NUM_PORTS{is_io_rd}} & port_sel);
  assign io_wr_n   = ~({NUM_PORTS{is_io_wr}} & port_sel);
  assign dbus_oe_n = rom_rd_n & ram_rd_n & (&io_rd_n);

  assign sel_active = ~{rom_rd_n, ram_rd_n, ram_wr_n, io_rd_n, io_wr_n};

  always_comb begin
    p_one_select_r9: assert ($onehot0(sel_active))
      else $error("more than one select active");
    p_refresh_quiet_r5: assert (!(!mreq_n && !rfsh_n) || (sel_active == '0))
      else $error("select during refresh");
    p_intack_quiet_r6: assert (!(!iorq_n && !m1_n) || ((&io_rd_n) && (&io_wr_n)))
      else $error("port select during interrupt acknowledge");
    p_oe_needs_rd_r10: assert (dbus_oe_n || !rd_n)
      else $error("data bus enabled without read strobe");
    p_write_needs_wr_r2: assert ((ram_wr_n && (&io_wr_n)) || !wr_n)
      else $error("write select without write strobe");
    p_conflict_quiet_r7: assert (!((!rd_n && !wr_n) || (!mreq_n && !iorq_n)) || (sel_active == '0))
      else $error("select during conflicting strobes");
  end

endmodule

// File: tb/sim_bus_cycle_decoder.sv
module sim_bus_cycle_decoder;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic        rfsh_n = 1'b1, m1_n = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic        rom_rd_n, ram_rd_n, ram_wr_n, dbus_oe_n;
  logic [3:0]  io_rd_n, io_wr_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  bus_cycle_decoder u0 (
    .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .rfsh_n(rfsh_n), .m1_n(m1_n), .addr(addr),
    .rom_rd_n(rom_rd_n), .ram_rd_n(ram_rd_n), .ram_wr_n(ram_wr_n),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .dbus_oe_n(dbus_oe_n)
  );

  // Packed view: {rom_rd, ram_rd, ram_wr, io_rd[3:0], io_wr[3:0]}, active high
  function automatic logic [10:0] act_vec();
    return ~{rom_rd_n, ram_rd_n, ram_wr_n, io_rd_n, io_wr_n};
  endfunction

  // Independent model of the requirements; also names the governing requirement
  function automatic logic [10:0] model(input logic [5:0] s, input logic [15:0] a,
                                        output string tag);
    logic m, i, r, w, f, o;
    logic [10:0] e;
    int lo;
    {m, i, r, w, f, o} = ~s;
    e = '0;
    lo = int'(a[7:0]);
    if ((r && w) || (m && i)) tag = "R7";
    else if (m && f) tag = "R5";
    else if (i && o) tag = "R6";
    else if (!(r || w) || !(m || i)) tag = "R8";
    else if (m) begin
      if (a >= 16'hC000) tag = "R3";
      else if (r) begin
        tag = "R1";
        if (a < 16'h4000) e[10] = 1'b1; else e[9] = 1'b1;
      end else begin
        tag = "R2";
        if (a >= 16'h4000) e[8] = 1'b1;
      end
    end else begin
      tag = "R4";
      if (lo >= 16 && lo < 32) begin
        if (r) e[4 + (lo - 16) / 4] = 1'b1;
        else   e[(lo - 16) / 4] = 1'b1;
      end
    end
    return e;
  endfunction

  task automatic apply(input logic [5:0] s, input logic [15:0] a);
    logic [10:0] exp_v, got;
    string tag;
    @(posedge clk);
    {mreq_n, iorq_n, rd_n, wr_n, rfsh_n, m1_n} = s;
    addr = a;
    @(negedge clk);
    exp_v = model(s, a, tag);
    got = act_vec();
    n_tests++;
    if (got !== exp_v) begin
      n_fail++;
      $display("FAIL %s strobes=%b addr=%h selects got=%b exp=%b", tag, s, a, got, exp_v);
    end
    n_tests++;
    if ($countones(got) > 1) begin
      n_fail++;
      $display("FAIL R9 strobes=%b addr=%h selects got=%b exp=at most one", s, a, got);
    end
    n_tests++;
    if (dbus_oe_n !== ~(|exp_v[10:4] & ~exp_v[8])) begin
      n_fail++;
      $display("FAIL R10 strobes=%b addr=%h oe_n got=%b exp=%b", s, a, dbus_oe_n,
               ~(|exp_v[10:4] & ~exp_v[8]));
    end
  endtask

  localparam int NB = 16;
  logic [15:0] edges [NB] = '{16'h0000, 16'h3FFF, 16'h4000, 16'h4001, 16'hBFFF, 16'hC000,
                              16'hFFFF, 16'h000F, 16'h0010, 16'h0013, 16'h0014, 16'hA51B,
                              16'h7F1C, 16'hFF1F, 16'h0020, 16'hC010};

  initial begin
    // R8: initial idle state, all strobes high
    #1;
    n_tests++;
    if (act_vec() !== '0 || dbus_oe_n !== 1'b1) begin
      n_fail++;
      $display("FAIL R8 idle selects got=%b oe_n=%b exp=0 1", act_vec(), dbus_oe_n);
    end
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < 64; s++) apply(6'(s), edges[b]);
    for (int a = 0; a < 65536; a += 247)
      for (int s = 0; s < 64; s++) apply(6'(s), 16'(a));
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule